// File: doc/BRIEF.md
# Splittable Up/Down Synchronous Counter

A 32-bit variable incrementer/decrementer built from eight 4-bit slices. All the slices run on one clock. Carry and borrow do not pass between slices as ripple clocks. They pass as same-cycle enables, so a slice advances only when every slice below it in the same segment sits at its terminal value for the chosen direction. A slice that is not enabled keeps its value. This keeps the whole 32-bit step within one clock period.

A split control cuts the chain between bit 15 and bit 16, which turns the block into two independent 16-bit counters. Each counter then takes its own increment and decrement request. Software loads the count one byte at a time from an 8-bit bus and reads it back one byte at a time. A byte write in a given cycle freezes all counting in that cycle.

Top module: `updown_split_counter`

## Requirements
- R1: After reset the count is zero.
- R2: With split low, inc_i[0]=1 and dec_i[0]=0 and no write, the count becomes count+1 modulo 2^32 on the next edge, carrying across every slice (0xFFFFFFFF becomes 0x00000000).
- R3: With split low, dec_i[0]=1 and inc_i[0]=0 and no write, the count becomes count-1 modulo 2^32 (0x00000000 becomes 0xFFFFFFFF).
- R4: When inc and dec of a segment are both 1, that segment holds its value.
- R5: With split high, no carry or borrow crosses from bit 15 to bit 16. A low-half wrap leaves bits 31:16 unchanged.
- R6: With split high, inc_i[0]/dec_i[0] drive bits 15:0 and inc_i[1]/dec_i[1] drive bits 31:16. With split low, inc_i[1] and dec_i[1] have no effect.
- R7: A write (wr_i=1) stores data_i into byte sel_i (0 = bits 7:0, 1 = 15:8, 2 = 23:16, 3 = 31:24) and leaves the other bytes unchanged.
- R8: A write takes priority over counting. In a write cycle no slice counts, whatever inc_i and dec_i are.
- R9: rd_data_o always shows byte sel_i of the current count, combinationally, using the same byte numbering as R7.
- R10: max_o[0]/max_o[1] are 1 exactly when bits 15:0 or bits 31:16 are all ones, and min_o[0]/min_o[1] exactly when they are all zeros. max_full_o and min_full_o give the same flags for all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| split_i | input | 1 | 1 = two 16-bit counters |
| inc_i | input | 2 | Increment request: [0] full/low half, [1] high half |
| dec_i | input | 2 | Decrement request: [0] full/low half, [1] high half |
| wr_i | input | 1 | Byte write strobe |
| sel_i | input | 2 | Byte select for write and read |
| data_i | input | 8 | Write data |
| count_o | output | 32 | Current count |
| max_o | output | 2 | Per-half all-ones flags |
| min_o | output | 2 | Per-half all-zeros flags |
| max_full_o | output | 1 | 32-bit all-ones flag |
| min_full_o | output | 1 | 32-bit all-zeros flag |
| rd_data_o | output | 8 | Selected byte of the count |

## Verification
A byte write and a count request can land in the same cycle. The bench loads 0x000000FF, then holds inc_i[0] high while it writes byte 2. A correct design gives 0x00AB00FF, which shows that the write landed and that the pending carry out of byte 0 was dropped. The split boundary is tested the same way: the low half wraps in the same cycle that the high half is asked to hold, and then in the same cycle that the high half is asked to count the other way.

// File: rtl/updown_cnt_pkg.sv
`timescale 1ns/1ps
package updown_cnt_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

    function automatic step_e decode_step(input logic up, input logic dn);
        if (up && !dn)      return STEP_UP;
        else if (dn && !up) return STEP_DOWN;
        else                return STEP_HOLD;
    endfunction
endpackage

// File: rtl/updown_slice.sv
`timescale 1ns/1ps
module updown_slice #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_up_i,
    input  logic         en_dn_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] q_o,
    output logic         ones_o,
    output logic         zeros_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] val;
    } slice_t;

    slice_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_i)         s_d.val = ld_val_i;
        else if (en_up_i) s_d.val = s_q.val + ONE;
        else if (en_dn_i) s_d.val = s_q.val - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o     = s_q.val;
    assign ones_o  = &s_q.val;
    assign zeros_o = ~|s_q.val;

    // an idle slice keeps its value (R4, R5)
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !en_up_i && !en_dn_i) |=> $stable(q_o));
    // cascade never asks for both directions at once (R4)
    p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_up_i && en_dn_i));
endmodule

// File: rtl/updown_cascade.sv
`timescale 1ns/1ps
module updown_cascade #(
    parameter int NUM_SLICES = 8
) (
    input  logic                  split_i,
    input  logic                  freeze_i,
    input  logic [1:0]            up_req_i,
    input  logic [1:0]            dn_req_i,
    input  logic [NUM_SLICES-1:0] ones_i,
    input  logic [NUM_SLICES-1:0] zeros_i,
    output logic [NUM_SLICES-1:0] en_up_o,
    output logic [NUM_SLICES-1:0] en_dn_o
);
    localparam int SPLIT_AT = NUM_SLICES / 2;

    logic carry_up, carry_dn;

    always_comb begin
        carry_up = 1'b0;
        carry_dn = 1'b0;
        en_up_o  = '0;
        en_dn_o  = '0;
        for (int k = 0; k < NUM_SLICES; k++) begin
            if (k == 0) begin
                carry_up = up_req_i[0];
                carry_dn = dn_req_i[0];
            end else if (split_i && k == SPLIT_AT) begin
                carry_up = up_req_i[1];
                carry_dn = dn_req_i[1];
            end
            en_up_o[k] = carry_up & ~freeze_i;
            en_dn_o[k] = carry_dn & ~freeze_i;
            carry_up   = carry_up & ones_i[k];
            carry_dn   = carry_dn & zeros_i[k];
        end
    end
endmodule

// File: rtl/updown_split_counter.sv
`timescale 1ns/1ps
module updown_split_counter
    import updown_cnt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SLICE_W = 4,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_i,
    input  logic [1:0]        inc_i,
    input  logic [1:0]        dec_i,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [1:0]        max_o,
    output logic [1:0]        min_o,
    output logic              max_full_o,
    output logic              min_full_o,
    output logic [BYTE_W-1:0] rd_data_o
);
    localparam int NUM_SLICES = CNT_W / SLICE_W;
    localparam int PER_BYTE   = BYTE_W / SLICE_W;
    localparam int HALF_W     = CNT_W / 2;
    localparam int HALF_SL    = NUM_SLICES / 2;

    logic [NUM_SLICES-1:0] ones, zeros, en_up, en_dn, ld;
    logic [1:0]            up_req, dn_req;
    step_e                 step_lo, step_hi;

    always_comb begin
        step_lo = decode_step(inc_i[0], dec_i[0]);
        step_hi = decode_step(inc_i[1], dec_i[1]);
        up_req  = {step_hi == STEP_UP,   step_lo == STEP_UP};
        dn_req  = {step_hi == STEP_DOWN, step_lo == STEP_DOWN};
    end

    updown_cascade #(.NUM_SLICES(NUM_SLICES)) u_cascade (
        .split_i  (split_i),
        .freeze_i (wr_i),
        .up_req_i (up_req),
        .dn_req_i (dn_req),
        .ones_i   (ones),
        .zeros_i  (zeros),
        .en_up_o  (en_up),
        .en_dn_o  (en_dn)
    );

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        assign ld[k] = wr_i && (int'(sel_i) == k / PER_BYTE);
        updown_slice #(.W(SLICE_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_up_i  (en_up[k]),
            .en_dn_i  (en_dn[k]),
            .ld_i     (ld[k]),
            .ld_val_i (data_i[(k % PER_BYTE)*SLICE_W +: SLICE_W]),
            .q_o      (count_o[k*SLICE_W +: SLICE_W]),
            .ones_o   (ones[k]),
            .zeros_o  (zeros[k])
        );
    end

    always_comb begin
        max_o[0]   = &ones[HALF_SL-1:0];
        max_o[1]   = &ones[NUM_SLICES-1:HALF_SL];
        min_o[0]   = &zeros[HALF_SL-1:0];
        min_o[1]   = &zeros[NUM_SLICES-1:HALF_SL];
        max_full_o = &max_o;
        min_full_o = &min_o;
        rd_data_o  = count_o[sel_i*BYTE_W +: BYTE_W];
    end

    p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> count_o == '0);
    p_full_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && !wr_i && inc_i[0] && !dec_i[0]) |=> count_o == $past(count_o) + CNT_W'(1));
    p_full_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && !wr_i && dec_i[0] && !inc_i[0]) |=> count_o == $past(count_o) - CNT_W'(1));
    p_both_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && !wr_i && inc_i[0] && dec_i[0]) |=> $stable(count_o));
    p_hi_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && !wr_i && (inc_i[1] == dec_i[1])) |=> $stable(count_o[CNT_W-1:HALF_W]));
    p_lo_own_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && !wr_i && (inc_i[0] == dec_i[0])) |=> $stable(count_o[HALF_W-1:0]));
    p_write_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> rd_data_o == $past(data_i) || sel_i != $past(sel_i));
    p_write_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i != 2'd0) |=> count_o[BYTE_W-1:0] == $past(count_o[BYTE_W-1:0]));
endmodule

// File: tb/updown_split_counter_tb.sv
`timescale 1ns/1ps
module updown_split_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_i = 1'b0;
    logic [1:0]  inc_i = '0, dec_i = '0, sel_i = '0;
    logic        wr_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic [31:0] count_o;
    logic [1:0]  max_o, min_o;
    logic        max_full_o, min_full_o;
    logic [7:0]  rd_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    updown_split_counter u_dut (
        .clk(clk), .rst_n(rst_n), .split_i(split_i), .inc_i(inc_i), .dec_i(dec_i),
        .wr_i(wr_i), .sel_i(sel_i), .data_i(data_i), .count_o(count_o),
        .max_o(max_o), .min_o(min_o), .max_full_o(max_full_o),
        .min_full_o(min_full_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        inc_i = '0; dec_i = '0; wr_i = 1'b0;
    endtask

    task automatic load_word(input logic [31:0] w);
        idle();
        for (int b = 0; b < 4; b++) begin
            wr_i = 1'b1; sel_i = 2'(b); data_i = w[b*8 +: 8];
            tick();
        end
        wr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset", count_o, 32'h0);
    endtask

    task automatic t_full_inc();
        split_i = 1'b0;
        load_word(32'hFFFF_FFFE);
        inc_i = 2'b01; tick();
        chk("R2 inc", count_o, 32'hFFFF_FFFF);
        tick();
        chk("R2 wrap", count_o, 32'h0);
        idle();
        load_word(32'h0000_FFFF);
        inc_i = 2'b01; tick();
        chk("R2 carry 15->16", count_o, 32'h0001_0000);
        idle();
    endtask

    task automatic t_full_dec();
        split_i = 1'b0;
        load_word(32'h0001_0000);
        dec_i = 2'b01; tick();
        chk("R3 borrow", count_o, 32'h0000_FFFF);
        idle();
        load_word(32'h0);
        dec_i = 2'b01; tick();
        chk("R3 wrap", count_o, 32'hFFFF_FFFF);
        tick();
        chk("R3 dec", count_o, 32'hFFFF_FFFE);
        idle();
    endtask

    task automatic t_both_hold();
        split_i = 1'b0;
        load_word(32'h1234_5678);
        inc_i = 2'b01; dec_i = 2'b01; tick();
        chk("R4 full hold", count_o, 32'h1234_5678);
        split_i = 1'b1; inc_i = 2'b11; dec_i = 2'b11; tick();
        chk("R4 split hold", count_o, 32'h1234_5678);
        idle(); split_i = 1'b0;
    endtask

    task automatic t_split();
        split_i = 1'b0;
        load_word(32'h1234_FFFF);
        split_i = 1'b1; inc_i = 2'b01; tick();
        chk("R5 no carry across", count_o, 32'h1234_0000);
        inc_i = 2'b10; dec_i = 2'b01; tick();
        chk("R5 R6 opposite halves", count_o, 32'h1235_FFFF);
        inc_i = 2'b00; dec_i = 2'b10; tick();
        chk("R6 hi own dec", count_o, 32'h1234_FFFF);
        idle(); split_i = 1'b0;
    endtask

    task automatic t_unsplit_ignore();
        split_i = 1'b0;
        load_word(32'h0000_0010);
        inc_i = 2'b10; tick();
        chk("R6 hi req ignored", count_o, 32'h0000_0010);
        inc_i = 2'b01; dec_i = 2'b10; tick();
        chk("R6 hi dec ignored", count_o, 32'h0000_0011);
        idle();
    endtask

    task automatic t_write_bytes();
        load_word(32'hA1B2_C3D4);
        chk("R7 word", count_o, 32'hA1B2_C3D4);
        wr_i = 1'b1; sel_i = 2'd1; data_i = 8'h5E; tick(); wr_i = 1'b0;
        chk("R7 byte1", count_o, 32'hA1B2_5ED4);
        for (int b = 0; b < 4; b++) begin
            sel_i = 2'(b); #1;
            chk("R9 read", {24'h0, rd_data_o}, {24'h0, 8'(32'hA1B2_5ED4 >> (b*8))});
        end
    endtask

    task automatic t_write_priority();
        split_i = 1'b0;
        load_word(32'h0000_00FF);
        inc_i = 2'b01; wr_i = 1'b1; sel_i = 2'd2; data_i = 8'hAB; tick();
        chk("R8 write beats inc", count_o, 32'h00AB_00FF);
        wr_i = 1'b0; inc_i = 2'b00; dec_i = 2'b01;
        wr_i = 1'b1; sel_i = 2'd0; data_i = 8'h00; tick();
        chk("R8 write beats dec", count_o, 32'h00AB_0000);
        idle();
    endtask

    task automatic t_flags();
        load_word(32'h0);
        chk("R10 zero", {26'h0, max_o, min_o, max_full_o, min_full_o}, {26'h0, 2'b00, 2'b11, 1'b0, 1'b1});
        load_word(32'hFFFF_0000);
        chk("R10 hi ones", {26'h0, max_o, min_o, max_full_o, min_full_o}, {26'h0, 2'b10, 2'b01, 1'b0, 1'b0});
        load_word(32'hFFFF_FFFF);
        chk("R10 all ones", {26'h0, max_o, min_o, max_full_o, min_full_o}, {26'h0, 2'b11, 2'b00, 1'b1, 1'b0});
        load_word(32'h0000_FFFE);
        chk("R10 near", {26'h0, max_o, min_o, max_full_o, min_full_o}, {26'h0, 2'b00, 2'b10, 1'b0, 1'b0});
    endtask

    initial begin
        t_reset();
        t_full_inc();
        t_full_dec();
        t_both_hold();
        t_split();
        t_unsplit_ignore();
        t_write_bytes();
        t_write_priority();
        t_flags();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule